// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 16-bit offset of a memory operand. Each request carries an addressing-mode code and selectors for a base register and an index register. It also carries a displacement with a width flag. The block receives the current contents of the two base registers (BX, BP) and the two index registers (SI, DI) from the register file. It picks the terms the mode calls for and adds them modulo 2^16.

The result is captured in an output register. A single-cycle valid pulse comes with it, one clock after each accepted request. A flag is produced alongside the offset. It reports whether BP took part in the sum, so a later stage can pick the stack segment by default. Instruction decoding, segment relocation and the register file sit outside this block.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (direct) yields the full 16-bit displacement as the address, whatever the width flag says, with the BP flag clear.
- R2: Mode code 1 (register indirect) yields one register picked by the 2-bit indirect selector: 0 gives SI, 1 gives DI, 2 gives BX, 3 gives BP. The displacement is ignored.
- R3: Mode code 2 (based) yields base + displacement. The base selector picks BX when 0 and BP when 1.
- R4: Mode code 3 (indexed) yields index + displacement. The index selector picks SI when 0 and DI when 1.
- R5: Mode code 4 (based-indexed) yields base + index. The displacement is ignored.
- R6: Mode code 5 (based-indexed with displacement) yields base + index + displacement.
- R7: In modes 2, 3 and 5, a width flag of 0 sign-extends the low 8 displacement bits to 16 bits and ignores the upper 8. A width flag of 1 uses all 16 bits.
- R8: Every sum wraps modulo 2^16; a carry out of bit 15 is dropped.
- R9: The BP flag is 1 exactly when BP is one of the summed terms, and 0 otherwise.
- R10: An accepted request (request valid high at a rising edge) updates the address and flag at that edge. The valid output is high for exactly the following cycle. Back-to-back requests give back-to-back results.
- R11: Without a request, the address and flag outputs hold their last values, whatever the other inputs do.
- R12: During and after reset, before any request, the valid output, the address and the BP flag are all 0.
- R13: The reserved mode codes 6 and 7 behave as direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe; the request is taken at the rising edge |
| mode | input | 3 | Addressing-mode code |
| baseSel | input | 1 | Base register pick: 0 BX, 1 BP |
| indexSel | input | 1 | Index register pick: 0 SI, 1 DI |
| indSel | input | 2 | Register pick for indirect mode: 0 SI, 1 DI, 2 BX, 3 BP |
| dispWide | input | 1 | 1 uses the full displacement, 0 the sign-extended low byte |
| disp | input | 16 | Instruction displacement |
| regBx | input | 16 | BX contents |
| regBp | input | 16 | BP contents |
| regSi | input | 16 | SI contents |
| regDi | input | 16 | DI contents |
| eaValid | output | 1 | One-cycle pulse marking a new result |
| eaOut | output | 16 | Effective address |
| bpUsed | output | 1 | BP took part in the sum |

## Verification
The assertions assume that the request strobe and every selector are at a known 0 or 1 at each rising edge. They also assume that no request is raised while reset is held, because the strobe-to-valid relation is only checked outside reset. The stimulus drives every input on the falling edge from a defined value and keeps the request low through reset. It moves selectors and register values only between edges, including during idle stretches where the outputs must hold.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_DIRECT      = 3'd0;
  localparam logic [MODE_W-1:0] MODE_INDIRECT    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_BASED       = 3'd2;
  localparam logic [MODE_W-1:0] MODE_INDEXED     = 3'd3;
  localparam logic [MODE_W-1:0] MODE_BASEIDX     = 3'd4;
  localparam logic [MODE_W-1:0] MODE_BASEIDXDISP = 3'd5;

  localparam logic [1:0] IND_SI = 2'd0;
  localparam logic [1:0] IND_DI = 2'd1;
  localparam logic [1:0] IND_BX = 2'd2;
  localparam logic [1:0] IND_BP = 2'd3;

  typedef struct packed {
    logic load;
    logic useBase;
    logic baseBp;
    logic useIndex;
    logic indexDi;
    logic useDisp;
    logic dispShort;
  } eaStrobe_t;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] mode,
  input  logic              baseSel,
  input  logic              indexSel,
  input  logic [1:0]        indSel,
  input  logic              dispWide,
  output eaStrobe_t         strobe
);

  always_comb begin
    strobe = '0;
    strobe.load = reqValid;
    case (mode)
      MODE_INDIRECT: begin
        case (indSel)
          IND_SI: begin strobe.useIndex = 1'b1; strobe.indexDi = 1'b0; end
          IND_DI: begin strobe.useIndex = 1'b1; strobe.indexDi = 1'b1; end
          IND_BX: begin strobe.useBase  = 1'b1; strobe.baseBp  = 1'b0; end
          default: begin strobe.useBase = 1'b1; strobe.baseBp  = 1'b1; end
        endcase
      end
      MODE_BASED: begin
        strobe.useBase   = 1'b1;
        strobe.baseBp    = baseSel;
        strobe.useDisp   = 1'b1;
        strobe.dispShort = ~dispWide;
      end
      MODE_INDEXED: begin
        strobe.useIndex  = 1'b1;
        strobe.indexDi   = indexSel;
        strobe.useDisp   = 1'b1;
        strobe.dispShort = ~dispWide;
      end
      MODE_BASEIDX: begin
        strobe.useBase  = 1'b1;
        strobe.baseBp   = baseSel;
        strobe.useIndex = 1'b1;
        strobe.indexDi  = indexSel;
      end
      MODE_BASEIDXDISP: begin
        strobe.useBase   = 1'b1;
        strobe.baseBp    = baseSel;
        strobe.useIndex  = 1'b1;
        strobe.indexDi   = indexSel;
        strobe.useDisp   = 1'b1;
        strobe.dispShort = ~dispWide;
      end
      default: begin
        // direct and the reserved codes: full displacement only
        strobe.useDisp   = 1'b1;
        strobe.dispShort = 1'b0;
      end
    endcase
  end

  // R1 / R13: direct and reserved codes select the displacement alone
  a_r1_direct_disp_only: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DIRECT || mode > MODE_BASEIDXDISP) |->
      (strobe.useDisp && !strobe.dispShort && !strobe.useBase && !strobe.useIndex));

  // R2: indirect picks exactly one register and no displacement
  a_r2_indirect_single: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_INDIRECT) |->
      ($countones({strobe.useBase, strobe.useIndex}) == 1 && !strobe.useDisp));

  // R5: based-indexed leaves the displacement out
  a_r5_no_disp: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BASEIDX) |-> (!strobe.useDisp && strobe.useBase && strobe.useIndex));

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobe_t         strobe,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  output logic              eaValid,
  output logic [ADDR_W-1:0] eaOut,
  output logic              bpUsed
);

  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] dispShortExt;
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] sumNext;
  logic              bpNext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign dispShortExt = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_nosext
      assign dispShortExt = disp;
    end
  endgenerate

  always_comb begin
    baseTerm  = '0;
    indexTerm = '0;
    dispTerm  = '0;
    if (strobe.useBase)  baseTerm  = strobe.baseBp  ? regBp : regBx;
    if (strobe.useIndex) indexTerm = strobe.indexDi ? regDi : regSi;
    if (strobe.useDisp)  dispTerm  = strobe.dispShort ? dispShortExt : disp;
    sumNext = baseTerm + indexTerm + dispTerm;
    bpNext  = strobe.useBase & strobe.baseBp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaValid <= 1'b0;
      eaOut   <= '0;
      bpUsed  <= 1'b0;
    end else begin
      eaValid <= strobe.load;
      if (strobe.load) begin
        eaOut  <= sumNext;
        bpUsed <= bpNext;
      end
    end
  end

  // R10: a request gives valid on the next cycle, no request gives none
  a_r10_valid_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> eaValid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !eaValid);

  // R11: outputs hold while idle
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(eaOut) && $stable(bpUsed)));

  // R9: flag follows BP participation in the accepted request
  a_r9_bp_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.useBase && strobe.baseBp) |=> bpUsed);
  a_r9_bp_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !(strobe.useBase && strobe.baseBp)) |=> !bpUsed);

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        mode,
  input  logic              baseSel,
  input  logic              indexSel,
  input  logic [1:0]        indSel,
  input  logic              dispWide,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  output logic              eaValid,
  output logic [ADDR_W-1:0] eaOut,
  output logic              bpUsed
);

  eaStrobe_t strobe;

  eag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .mode     (mode),
    .baseSel  (baseSel),
    .indexSel (indexSel),
    .indSel   (indSel),
    .dispWide (dispWide),
    .strobe   (strobe)
  );

  eag_datapath #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .disp    (disp),
    .regBx   (regBx),
    .regBp   (regBp),
    .regSi   (regSi),
    .regDi   (regDi),
    .eaValid (eaValid),
    .eaOut   (eaOut),
    .bpUsed  (bpUsed)
  );

endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        baseSel = 1'b0;
  logic        indexSel = 1'b0;
  logic [1:0]  indSel = 2'd0;
  logic        dispWide = 1'b0;
  logic [15:0] disp = 16'h0;
  logic [15:0] regBx = 16'h1234;
  logic [15:0] regBp = 16'hF000;
  logic [15:0] regSi = 16'h0010;
  logic [15:0] regDi = 16'h8001;
  logic        eaValid;
  logic [15:0] eaOut;
  logic        bpUsed;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .baseSel(baseSel), .indexSel(indexSel), .indSel(indSel),
    .dispWide(dispWide), .disp(disp), .regBx(regBx), .regBp(regBp),
    .regSi(regSi), .regDi(regDi), .eaValid(eaValid), .eaOut(eaOut),
    .bpUsed(bpUsed)
  );

  // {mode, baseSel, indexSel, indSel, dispWide, disp, expEa, expBp}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b1, 2'd3, 1'b0, 16'hABCD, 16'hABCD, 1'b0}, // R1 width flag ignored
    {3'd1, 1'b0, 1'b0, 2'd0, 1'b1, 16'hFFFF, 16'h0010, 1'b0}, // R2 SI
    {3'd1, 1'b1, 1'b0, 2'd1, 1'b1, 16'hFFFF, 16'h8001, 1'b0}, // R2 DI
    {3'd1, 1'b1, 1'b1, 2'd2, 1'b0, 16'h00FF, 16'h1234, 1'b0}, // R2 BX
    {3'd1, 1'b0, 1'b0, 2'd3, 1'b0, 16'h0101, 16'hF000, 1'b1}, // R2 BP, R9
    {3'd2, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1280, 16'h11B4, 1'b0}, // R3 R7 short negative
    {3'd2, 1'b1, 1'b0, 2'd0, 1'b1, 16'h2000, 16'h1000, 1'b1}, // R3 R8 wrap, R9
    {3'd3, 1'b0, 1'b1, 2'd0, 1'b0, 16'hAA7F, 16'h8080, 1'b0}, // R4 R7 short positive
    {3'd3, 1'b1, 1'b0, 2'd3, 1'b1, 16'hFFF0, 16'h0000, 1'b0}, // R4 R8 wrap to zero
    {3'd4, 1'b0, 1'b0, 2'd3, 1'b1, 16'h5555, 16'h1244, 1'b0}, // R5 BX+SI
    {3'd4, 1'b1, 1'b1, 2'd0, 1'b0, 16'h5555, 16'h7001, 1'b1}, // R5 BP+DI wrap, R9
    {3'd5, 1'b0, 1'b1, 2'd0, 1'b0, 16'h33FE, 16'h9233, 1'b0}, // R6 R7 BX+DI-2
    {3'd5, 1'b1, 1'b0, 2'd0, 1'b1, 16'h0FF0, 16'h0000, 1'b1}, // R6 R8 BP+SI+disp
    {3'd6, 1'b1, 1'b1, 2'd3, 1'b0, 16'h4321, 16'h4321, 1'b0}, // R13 code 6
    {3'd7, 1'b1, 1'b0, 2'd2, 1'b0, 16'h8000, 16'h8000, 1'b0}  // R13 code 7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic driveVec(input logic [40:0] v);
    mode     = v[40:38];
    baseSel  = v[37];
    indexSel = v[36];
    indSel   = v[35:34];
    dispWide = v[33];
    disp     = v[32:17];
    reqValid = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        finishRun();
      end
    end
  end

  initial begin
    logic [15:0] heldEa;
    logic        heldBp;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 valid", {31'd0, eaValid}, 32'd0);
    check("R12 ea", {16'd0, eaOut}, 32'd0);
    check("R12 bp", {31'd0, bpUsed}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 after release valid", {31'd0, eaValid}, 32'd0);
    check("R12 after release ea", {16'd0, eaOut}, 32'd0);

    // table walk, one request at a time (R1-R9, R13, R10)
    for (int i = 0; i < NV; i++) begin
      driveVec(VEC[i]);
      @(negedge clk);
      reqValid = 1'b0;
      check($sformatf("R10 valid vec%0d", i), {31'd0, eaValid}, 32'd1);
      check($sformatf("R1-6 ea vec%0d", i), {16'd0, eaOut}, {16'd0, VEC[i][16:1]});
      check($sformatf("R9 bp vec%0d", i), {31'd0, bpUsed}, {31'd0, VEC[i][0]});
      @(negedge clk);
      check($sformatf("R10 pulse ends vec%0d", i), {31'd0, eaValid}, 32'd0);
    end

    // R11: idle with changing inputs keeps outputs
    driveVec(VEC[4]);  // BP indirect -> F000, flag 1
    @(negedge clk);
    reqValid = 1'b0;
    heldEa = eaOut;
    heldBp = bpUsed;
    check("R11 setup ea", {16'd0, heldEa}, 32'h0000F000);
    for (int k = 0; k < 4; k++) begin
      mode  = 3'(k);
      indSel = 2'(k);
      disp  = 16'h1111 * 16'(k + 1);
      regBp = regBp + 16'h0100;
      regBx = regBx ^ 16'hFFFF;
      @(negedge clk);
      check("R11 hold ea", {16'd0, eaOut}, {16'd0, heldEa});
      check("R11 hold bp", {31'd0, bpUsed}, {31'd0, heldBp});
      check("R11 no valid", {31'd0, eaValid}, 32'd0);
    end
    regBx = 16'h1234;
    regBp = 16'hF000;

    // R10: back-to-back requests
    driveVec(VEC[6]);   // BP + 2000 -> 1000, flag 1
    @(negedge clk);
    check("R10 b2b first valid", {31'd0, eaValid}, 32'd1);
    check("R10 b2b first ea", {16'd0, eaOut}, 32'h00001000);
    driveVec(VEC[9]);   // BX + SI -> 1244, flag 0
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 b2b second valid", {31'd0, eaValid}, 32'd1);
    check("R10 b2b second ea", {16'd0, eaOut}, 32'h00001244);
    check("R9 b2b second bp", {31'd0, bpUsed}, 32'd0);
    @(negedge clk);
    check("R10 b2b end", {31'd0, eaValid}, 32'd0);

    // R7: 8-bit value with upper byte set and width flag 0, full wrap sum (R8)
    regBx = 16'hFFFF;
    mode = 3'd2; baseSel = 1'b0; dispWide = 1'b0; disp = 16'h7F01; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R7 R8 short ext wrap", {16'd0, eaOut}, 32'h00000000);

    // R12: reset mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R12 re-reset ea", {16'd0, eaOut}, 32'd0);
    check("R12 re-reset bp", {31'd0, bpUsed}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    finishRun();
  end

endmodule